// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Generator

This block turns the fill counts of a 256-entry receive FIFO and a 256-entry transmit FIFO into two level conditions: a receive request that rises as the receive FIFO fills up to a chosen trigger, and a transmit request that rises as the transmit FIFO drains below a chosen trigger. Each side takes its own 2-bit trigger code. The two sides work in opposite directions: the receive request means "enough data to read", and the transmit request means "enough room to write". Both requests can feed an interrupt arbiter or act as DMA request lines.

The block registers each fill count on the rising clock edge, clamping values above the FIFO depth to the depth. The two requests are decoded combinationally from those registered counts, so an output follows a push or pop one cycle later. The trigger codes are applied straight to the decoders, with no register in between. Because the receive request is a plain level compare, the full trigger re-arms by itself. The request drops when a read leaves a free place. It rises again when a character waiting in the receive shift register moves into the FIFO and fills it.

Top module: `fifo_level_irq`

## Requirements
- R1: While rst_ni is low the captured counts are zero, so rx_int_o is 0 and tx_int_o is 1, whatever the count inputs are.
- R2: With rx_trig_i = 2'b00, rx_int_o is 1 exactly when the receive count is at least 1.
- R3: With rx_trig_i = 2'b01, rx_int_o is 1 exactly when the receive count is at least 128 (half full).
- R4: With rx_trig_i = 2'b10, rx_int_o is 1 exactly when the receive count is at least 192 (three quarters full).
- R5: With rx_trig_i = 2'b11, rx_int_o is 1 only at a count of 256. It drops when the count falls to 255 and rises again when the count returns to 256.
- R6: rx_int_o is 0 whenever the receive count is 0, under every trigger code.
- R7: With tx_trig_i = 2'b00, tx_int_o is 1 only when the transmit count is 0.
- R8: tx_int_o is 1 exactly when the transmit count is below 192 for tx_trig_i = 2'b01, below 128 for 2'b10, and below 64 for 2'b11.
- R9: tx_int_o is 0 whenever the transmit count is 256, under every trigger code.
- R10: Each output reflects the count sampled at the previous rising clock edge and the trigger code currently applied.
- R11: A count input above 256 is treated as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_count_i | input | 9 | Receive FIFO fill count |
| rx_trig_i | input | 2 | Receive trigger code |
| tx_count_i | input | 9 | Transmit FIFO fill count |
| tx_trig_i | input | 2 | Transmit trigger code |
| rx_int_o | output | 1 | Receive level request |
| tx_int_o | output | 1 | Transmit level request |

## Verification
For every trigger code, a full sweep runs the receive count upward from 0 to 256 while the transmit count runs downward. This places a check on both sides of every threshold, which separates an off-by-one compare from a correct one and catches a swapped code. A fill, drain and refill sequence at the full trigger confirms that the request re-arms. Counts above the depth exercise the clamping. Asserting the count inputs during reset shows that the outputs come from captured state rather than from the raw inputs. Checking every result in the cycle after it was driven pins down the one-cycle latency.

// File: rtl/fli_pkg.sv
package fli_pkg;
  typedef enum logic [1:0] {
    RX_READY = 2'b00,
    RX_HALF  = 2'b01,
    RX_3Q    = 2'b10,
    RX_FULL  = 2'b11
  } rx_trig_e;

  typedef enum logic [1:0] {
    TX_EMPTY = 2'b00,
    TX_3Q    = 2'b01,
    TX_HALF  = 2'b10,
    TX_1Q    = 2'b11
  } tx_trig_e;
endpackage

// File: rtl/fli_fill_capture.sv
module fli_fill_capture #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] MaxCnt = CW'(DEPTH);

  logic [CW-1:0] cnt_clamped;
  assign cnt_clamped = (cnt_i > MaxCnt) ? MaxCnt : cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_clamped;
  end
endmodule

// File: rtl/fli_rx_detect.sv
module fli_rx_detect
  import fli_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] cnt_i,
  input  rx_trig_e      trig_i,
  output logic          req_o
);
  localparam logic [CW-1:0] ThrHalf = CW'(DEPTH / 2);
  localparam logic [CW-1:0] Thr3q   = CW'((3 * DEPTH) / 4);
  localparam logic [CW-1:0] ThrFull = CW'(DEPTH);

  logic [CW-1:0] thr;
  always_comb begin
    unique case (trig_i)
      RX_READY: thr = CW'(1);
      RX_HALF:  thr = ThrHalf;
      RX_3Q:    thr = Thr3q;
      default:  thr = ThrFull;
    endcase
  end

  // thr >= 1 keeps an empty FIFO out of arbitration
  assign req_o = (cnt_i >= thr);
endmodule

// File: rtl/fli_tx_detect.sv
module fli_tx_detect
  import fli_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] cnt_i,
  input  tx_trig_e      trig_i,
  output logic          req_o
);
  localparam logic [CW-1:0] Thr3q = CW'((3 * DEPTH) / 4);
  localparam logic [CW-1:0] ThrHf = CW'(DEPTH / 2);
  localparam logic [CW-1:0] Thr1q = CW'(DEPTH / 4);

  logic [CW-1:0] thr;
  always_comb begin
    unique case (trig_i)
      TX_EMPTY: thr = CW'(1);
      TX_3Q:    thr = Thr3q;
      TX_HALF:  thr = ThrHf;
      default:  thr = Thr1q;
    endcase
  end

  // every thr <= DEPTH, so a full FIFO never requests
  assign req_o = (cnt_i < thr);
endmodule

// File: rtl/fifo_level_irq.sv
module fifo_level_irq
  import fli_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] rx_count_i,
  input  logic [1:0]    rx_trig_i,
  input  logic [CW-1:0] tx_count_i,
  input  logic [1:0]    tx_trig_i,
  output logic          rx_int_o,
  output logic          tx_int_o
);
  logic [CW-1:0] rx_cnt_q, tx_cnt_q;

  fli_fill_capture #(.DEPTH(DEPTH), .CW(CW)) i_rx_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(rx_count_i), .cnt_o(rx_cnt_q)
  );

  fli_fill_capture #(.DEPTH(DEPTH), .CW(CW)) i_tx_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(tx_count_i), .cnt_o(tx_cnt_q)
  );

  fli_rx_detect #(.DEPTH(DEPTH), .CW(CW)) i_rx_det (
    .cnt_i(rx_cnt_q), .trig_i(rx_trig_e'(rx_trig_i)), .req_o(rx_int_o)
  );

  fli_tx_detect #(.DEPTH(DEPTH), .CW(CW)) i_tx_det (
    .cnt_i(tx_cnt_q), .trig_i(tx_trig_e'(tx_trig_i)), .req_o(tx_int_o)
  );
endmodule

// File: rtl/fli_checker.sv
module fli_checker #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] rx_count_i,
  input logic [1:0]    rx_trig_i,
  input logic [CW-1:0] tx_count_i,
  input logic [1:0]    tx_trig_i,
  input logic          rx_int_o,
  input logic          tx_int_o
);
  localparam logic [CW-1:0] Full = CW'(DEPTH);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) begin
      p_reset_r1: assert (!rx_int_o && tx_int_o);
    end
  end

  p_rx_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && rx_trig_i == 2'b00 && $past(rx_count_i) != '0 |-> rx_int_o);

  p_rx_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && rx_trig_i == 2'b11 |-> rx_int_o == ($past(rx_count_i) >= Full));

  p_rx_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(rx_count_i) == '0 |-> !rx_int_o);

  p_tx_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(tx_count_i) == '0 |-> tx_int_o);

  p_tx_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(tx_count_i) >= Full |-> !tx_int_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $stable(rx_count_i) && $stable(rx_trig_i) |=> $stable(rx_int_o));
endmodule

bind fifo_level_irq fli_checker #(.DEPTH(DEPTH), .CW(CW)) i_fli_checker (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .rx_count_i(rx_count_i), .rx_trig_i(rx_trig_i),
  .tx_count_i(tx_count_i), .tx_trig_i(tx_trig_i),
  .rx_int_o(rx_int_o), .tx_int_o(tx_int_o)
);

// File: tb/test_fifo_level_irq.sv
`timescale 1ns/1ps
module test_fifo_level_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] rx_cnt = '0, tx_cnt = '0;
  logic [1:0] rx_trig = '0, tx_trig = '0;
  logic       rx_int, tx_int;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    rx;
    bit    tx;
    string req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  fifo_level_irq i_fifo_level_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_count_i(rx_cnt), .rx_trig_i(rx_trig),
    .tx_count_i(tx_cnt), .tx_trig_i(tx_trig),
    .rx_int_o(rx_int), .tx_int_o(tx_int)
  );

  function automatic bit model_rx(int c, int code);
    int thr[4] = '{1, 128, 192, 256};
    if (c > 256) c = 256;
    return c >= thr[code];
  endfunction

  function automatic bit model_tx(int c, int code);
    int thr[4] = '{1, 192, 128, 64};
    if (c > 256) c = 256;
    return c < thr[code];
  endfunction

  task automatic check(bit act_rx, bit act_tx, exp_t e);
    checks++;
    if (act_rx !== e.rx || act_tx !== e.tx) begin
      errors++;
      $display("FIFO check FAIL %s: rx_int=%0b tx_int=%0b expected rx_int=%0b tx_int=%0b",
               e.req, act_rx, act_tx, e.rx, e.tx);
    end
  endtask

  // driver: apply at negedge, expect result after the next posedge
  task automatic apply(int rc, int rt, int tc, int tt, string req);
    exp_t e;
    @(negedge clk);
    rx_cnt = 9'(rc); rx_trig = 2'(rt);
    tx_cnt = 9'(tc); tx_trig = 2'(tt);
    e.rx = model_rx(rc, rt);
    e.tx = model_tx(tc, tt);
    e.req = req;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) check(rx_int, tx_int, sb.pop_front());
    end
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FIFO check FAIL watchdog: run did not complete, expected completion");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    exp_t r;
    // R1: inputs active during reset must not reach the outputs
    rx_cnt = 9'd200; tx_cnt = 9'd256;
    repeat (3) @(posedge clk);
    #2;
    r.rx = 1'b0; r.tx = 1'b1; r.req = "R1";
    check(rx_int, tx_int, r);
    @(negedge clk);
    rst_n = 1'b1;

    // sweep: rx fills up, tx drains, every trigger code
    for (int code = 0; code < 4; code++) begin
      for (int c = 0; c <= 256; c++) begin
        string tag;
        if (c == 0) tag = "R6/R9";
        else if (code == 0) tag = "R2/R7";
        else if (code == 1) tag = "R3/R8";
        else if (code == 2) tag = "R4/R8";
        else tag = "R5/R8";
        apply(c, code, 256 - c, code, tag);
      end
    end

    // R5: full trigger drops on one read, re-arms on refill from shift register
    apply(256, 3, 0, 0, "R5");
    apply(255, 3, 0, 0, "R5");
    apply(256, 3, 0, 0, "R5");
    apply(255, 3, 1, 0, "R5");

    // R6 / R9: empty rx and full tx under each code
    for (int code = 0; code < 4; code++) apply(0, code, 256, code, "R6/R9");

    // R11: counts above the depth
    apply(300, 3, 300, 1, "R11");
    apply(511, 0, 511, 3, "R11");

    // R10: back-to-back changes, each visible one cycle later
    apply(127, 1, 63, 3, "R10");
    apply(128, 1, 64, 3, "R10");
    apply(127, 1, 63, 3, "R10");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule